// File: doc/BRIEF.md
# IO Address Translation Unit

This block turns 32-bit DMA virtual addresses issued by a device into physical addresses. Software programs three registers through a simple write port: a control register that enables translation, selects the page size and sets the table size; a table base register; and a flush register. Each request is offered on a valid/ready channel. If translation is off, the address passes straight through. If it is on, the unit checks the address against a translation window. This window always ends at the top of the 32-bit space, and its size follows the table-size code. For an address inside the window, the unit computes the table slot, reads one 64-bit entry over a single-outstanding memory read port, checks that entry and returns either a physical address or a fault code on a second valid/ready channel.

The unit keeps the most recent successful translation in a one-entry cache. A repeat access to the same 8K page answers in one cycle without a memory read. Writing the flush register with the cached page drops the cached translation. Any write to the control or table base register also drops it.

Back-pressure works as follows. A new request is taken only while the unit is idle. A response stays on the outputs, unchanged, until it is accepted. An entry read request stays asserted, with a fixed address, until the memory port accepts it.

Top module: `iova_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and translation is disabled.
- R2: A register write with `reg_sel` 0 loads the control register: bit 0 enables translation, bit 2 selects 64K pages (0 means 8K), and bits 18:16 hold the size code n. `reg_sel` 1 loads the table base from bits 40:13. `reg_sel` 2 is the flush register, with the page number in bits 31:13.
- R3: With translation disabled, an accepted request gives `rsp_paddr` equal to the zero-extended request address and fault 0 in the cycle after acceptance, with no memory read.
- R4: With translation enabled, the window base is 0xFF800000 shifted left by n, truncated to 32 bits. An address below the base gives fault 1 (out of range), `rsp_paddr` 0 and no memory read.
- R5: For an address inside the window, the entry read address is table base + ((address − window base) >> 13) × 8.
- R6: For a usable entry, `rsp_paddr` is entry bits 40:13 joined with request address bits 12:0, with fault 0. A miss answers in the third cycle after acceptance when memory replies in the cycle after its request.
- R7: An entry with bit 63 clear gives fault 2 (invalid) and `rsp_paddr` 0.
- R8: A valid entry whose bit 61 differs from control bit 2 gives fault 4 (size mismatch). This takes priority over the write check.
- R9: A write request to a valid, size-matching entry with bit 1 clear gives fault 3 (protection) and `rsp_paddr` 0. A read request to the same entry succeeds.
- R10: After a valid, size-matching entry is fetched, a request to the same page answers from the cache one cycle after acceptance with no memory read, and the cached write permission still applies.
- R11: A flush write naming the cached page, or any write to the control or table base register, empties the cache. A flush naming a different page leaves it in place.
- R12: While `rsp_valid` is 1 and `rsp_ready` is 0, the response holds stable and `req_ready` stays 0. While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 table base, 2 flush |
| reg_wdata | input | 64 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_addr | input | 32 | DMA virtual address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result accepted |
| rsp_paddr | output | 41 | Physical address (0 on fault) |
| rsp_fault | output | 3 | 0 none, 1 range, 2 invalid, 3 protection, 4 size |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 41 | Entry byte address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |

## Verification
The assertions assume that memory returns exactly one `mem_rsp_valid` pulse for each accepted read and never sends data unprompted. They also assume that register writes do not land in the same cycle as a request is accepted. The bench respects both limits. Its memory model answers only in the cycle after a read handshake. Every register write is issued while the unit is idle, between whole request/response exchanges, and the only back-pressure the bench applies is on the response channel and the memory request port.

// File: rtl/iova_pkg.sv
package iova_pkg;
  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_PROTECT = 3'd3,
    FLT_SIZE    = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_TBASE = 2'd1,
    SEL_FLUSH = 2'd2,
    SEL_NONE  = 2'd3
  } regsel_e;

  localparam int ENT_VALID_BIT = 63;
  localparam int ENT_BIG_BIT   = 61;
  localparam int ENT_WRITE_BIT = 1;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_BIG_BIT  = 2;
  localparam int CTRL_CODE_LSB = 16;
endpackage

// File: rtl/iova_window.sv
module iova_window #(
  parameter int VA_W       = 32,
  parameter int PG_SH      = 13,
  parameter int CODE_W     = 3,
  parameter int MIN_WIN_SH = 23
) (
  input  logic [VA_W-1:0]       addr,
  input  logic [CODE_W-1:0]     code,
  output logic                  hit,
  output logic [VA_W-PG_SH-1:0] slot
);
  localparam logic [VA_W-1:0] ALL_ONES = '1;
  localparam int SLOT_SH = MIN_WIN_SH - PG_SH;

  logic [VA_W-1:0] base;
  logic [VA_W-1:0] off;

  always_comb begin
    base = ALL_ONES << (MIN_WIN_SH + int'(code));
    hit  = (addr >= base);
    off  = addr - base;
    slot = off[VA_W-1:PG_SH];
  end

  // R4: an address that hits the window indexes inside the table
  always_comb begin
    if (hit) begin
      a_r4_slot_in_table: assert (int'(slot) < (1 << (SLOT_SH + int'(code))));
    end
  end
endmodule

// File: rtl/iova_entry_chk.sv
module iova_entry_chk
  import iova_pkg::*;
#(
  parameter int PA_W  = 41,
  parameter int PG_SH = 13
) (
  input  logic [63:0]      entry,
  input  logic             is_write,
  input  logic             big_cfg,
  input  logic [PG_SH-1:0] page_ofs,
  output fault_e           fault,
  output logic [PA_W-1:0]  paddr
);
  logic unused_entry_bits;
  assign unused_entry_bits = ^{entry[62], entry[60:PA_W], entry[PG_SH-1:2], entry[0]};

  always_comb begin
    if (!entry[ENT_VALID_BIT])                fault = FLT_INVALID;
    else if (entry[ENT_BIG_BIT] != big_cfg)   fault = FLT_SIZE;
    else if (is_write && !entry[ENT_WRITE_BIT]) fault = FLT_PROTECT;
    else                                      fault = FLT_NONE;
    paddr = {entry[PA_W-1:PG_SH], page_ofs};
  end
endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
  import iova_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 41,
  parameter int PG_SH      = 13,
  parameter int CODE_W     = 3,
  parameter int MIN_WIN_SH = 23,
  parameter int ENT_BYTES  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [1:0]      reg_sel,
  input  logic [63:0]     reg_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_addr,
  input  logic            req_write,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [40:0]     rsp_paddr,
  output logic [2:0]      rsp_fault,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [40:0]     mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data
);
  localparam int VPN_W  = VA_W - PG_SH;
  localparam int PPN_W  = PA_W - PG_SH;
  localparam int ENT_SH = $clog2(ENT_BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT, ST_RESP} state_e;

  state_e            state;
  logic              ctrl_en, ctrl_big;
  logic [CODE_W-1:0] ctrl_code;
  logic [PPN_W-1:0]  tbase;
  logic [VA_W-1:0]   cur_addr;
  logic              cur_wr, kill;
  logic              c_vld, c_w;
  logic [VPN_W-1:0]  c_tag;
  logic [PPN_W-1:0]  c_ppn;

  logic              win_hit;
  logic [VPN_W-1:0]  win_slot;
  fault_e            chk_fault;
  logic [PA_W-1:0]   chk_pa;
  logic              accept, wr_ctrl, wr_tbase, wr_flush;
  logic              cache_hit, inval_cache, kill_now;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  iova_window #(.VA_W(VA_W), .PG_SH(PG_SH), .CODE_W(CODE_W), .MIN_WIN_SH(MIN_WIN_SH)) u_window (
    .addr(req_addr), .code(ctrl_code), .hit(win_hit), .slot(win_slot)
  );

  iova_entry_chk #(.PA_W(PA_W), .PG_SH(PG_SH)) u_chk (
    .entry(mem_rsp_data), .is_write(cur_wr), .big_cfg(ctrl_big),
    .page_ofs(cur_addr[PG_SH-1:0]), .fault(chk_fault), .paddr(chk_pa)
  );

  always_comb begin
    req_ready     = (state == ST_IDLE);
    rsp_valid     = (state == ST_RESP);
    mem_req_valid = (state == ST_FETCH);
    accept        = req_valid && req_ready;
    wr_ctrl       = reg_we && (regsel_e'(reg_sel) == SEL_CTRL);
    wr_tbase      = reg_we && (regsel_e'(reg_sel) == SEL_TBASE);
    wr_flush      = reg_we && (regsel_e'(reg_sel) == SEL_FLUSH);
    cache_hit     = c_vld && (c_tag == req_addr[VA_W-1:PG_SH]);
    inval_cache   = wr_ctrl || wr_tbase ||
                    (wr_flush && (reg_wdata[VA_W-1:PG_SH] == c_tag));
    kill_now      = wr_ctrl || wr_tbase ||
                    (wr_flush && (reg_wdata[VA_W-1:PG_SH] == cur_addr[VA_W-1:PG_SH]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      ctrl_en      <= 1'b0;
      ctrl_big     <= 1'b0;
      ctrl_code    <= '0;
      tbase        <= '0;
      cur_addr     <= '0;
      cur_wr       <= 1'b0;
      kill         <= 1'b0;
      c_vld        <= 1'b0;
      c_w          <= 1'b0;
      c_tag        <= '0;
      c_ppn        <= '0;
      rsp_paddr    <= '0;
      rsp_fault    <= FLT_NONE;
      mem_req_addr <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en   <= reg_wdata[CTRL_EN_BIT];
        ctrl_big  <= reg_wdata[CTRL_BIG_BIT];
        ctrl_code <= reg_wdata[CTRL_CODE_LSB +: CODE_W];
      end
      if (wr_tbase) tbase <= reg_wdata[PA_W-1:PG_SH];
      if (inval_cache) c_vld <= 1'b0;
      if ((state == ST_FETCH || state == ST_WAIT) && kill_now) kill <= 1'b1;

      case (state)
        ST_IDLE: if (accept) begin
          cur_addr <= req_addr;
          cur_wr   <= req_write;
          kill     <= 1'b0;
          if (!ctrl_en) begin
            rsp_paddr <= PA_W'(req_addr);
            rsp_fault <= FLT_NONE;
            state     <= ST_RESP;
          end else if (!win_hit) begin
            rsp_paddr <= '0;
            rsp_fault <= FLT_RANGE;
            state     <= ST_RESP;
          end else if (cache_hit) begin
            if (req_write && !c_w) begin
              rsp_paddr <= '0;
              rsp_fault <= FLT_PROTECT;
            end else begin
              rsp_paddr <= {c_ppn, req_addr[PG_SH-1:0]};
              rsp_fault <= FLT_NONE;
            end
            state <= ST_RESP;
          end else begin
            mem_req_addr <= {tbase, {PG_SH{1'b0}}} + (PA_W'(win_slot) << ENT_SH);
            state        <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          rsp_fault <= chk_fault;
          rsp_paddr <= (chk_fault == FLT_NONE) ? chk_pa : '0;
          if ((chk_fault == FLT_NONE || chk_fault == FLT_PROTECT) && !kill && !kill_now) begin
            c_vld <= 1'b1;
            c_tag <= cur_addr[VA_W-1:PG_SH];
            c_ppn <= mem_rsp_data[PA_W-1:PG_SH];
            c_w   <= mem_rsp_data[ENT_WRITE_BIT];
          end
          state <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12: response held under back-pressure
  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  // R12: entry read request held until taken
  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R12: no new request while a result is pending
  a_r12_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R5: entry reads are entry aligned
  a_r5_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[ENT_SH-1:0] == '0));

  // R3: bypass answers next cycle with the raw address
  a_r3_bypass_direct: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !ctrl_en |=> rsp_valid && (rsp_fault == 3'd0) &&
                           (rsp_paddr == PA_W'($past(req_addr))));

  // R4: out-of-range requests never start a fetch
  a_r4_range_nofetch: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ctrl_en && !win_hit |=> rsp_valid && (rsp_fault == 3'd1) && !mem_req_valid);
endmodule

// File: tb/test_iova_xlate.sv
`timescale 1ns/1ps
module test_iova_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [63:0] reg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [40:0] rsp_paddr;
  logic [2:0]  rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [40:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int checks = 0;
  int fails = 0;
  int fetches = 0;
  logic [40:0] last_fetch = '0;
  logic [63:0] mem [logic [40:0]];

  always #2.5 clk = ~clk;

  iova_xlate i_iova_xlate (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // memory model: one-cycle reply after each accepted read
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'd0;
      last_fetch    <= mem_req_addr;
      fetches       <= fetches + 1;
    end
  end

  localparam logic [40:0] TB = 41'h1_0000_2000;

  function automatic logic [63:0] mk_ent(logic v, logic big, logic w, logic [27:0] ppn);
    logic [63:0] e = '0;
    e[63] = v; e[61] = big; e[40:13] = ppn; e[1] = w;
    return e;
  endfunction

  function automatic logic [63:0] mk_ctrl(logic en, logic big, logic [2:0] code);
    return (64'(code) << 16) | (64'(big) << 2) | 64'(en);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] a, input logic w,
                       output logic [40:0] pa, output logic [2:0] f, output int cyc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!rsp_valid) begin
      @(negedge clk);
      cyc++;
    end
    pa = rsp_paddr; f = rsp_fault;
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 0);
  endtask

  task automatic t_bypass();
    logic [40:0] pa; logic [2:0] f; int c; int f0;
    f0 = fetches;
    xlate(32'h1234_5678, 1'b0, pa, f, c);
    check(pa == 41'h1234_5678 && f == 0, "R1 disabled after reset", pa, 41'h1234_5678);
    xlate(32'hFFFF_E123, 1'b1, pa, f, c);
    check(pa == 41'h0FFFF_E123 && f == 0, "R3 bypass paddr", pa, 41'h0FFFF_E123);
    check(c == 1, "R3 bypass latency", 64'(c), 1);
    check(fetches == f0, "R3 bypass no fetch", 64'(fetches), 64'(f0));
  endtask

  task automatic t_window();
    logic [40:0] pa; logic [2:0] f; int c; int f0;
    mem[TB]            = mk_ent(1, 0, 1, 28'h0ABCD);
    mem[TB + 41'h1FF8] = mk_ent(1, 0, 0, 28'h00777);
    mem[TB + 41'h8]    = mk_ent(1, 0, 1, 28'h12345);
    wr_reg(2'd1, 64'(TB));
    wr_reg(2'd0, mk_ctrl(1, 0, 3'd0));
    f0 = fetches;
    xlate(32'hFF7F_FFFF, 1'b0, pa, f, c);
    check(f == 3'd1 && pa == 0, "R4 below base code0", 64'(f), 1);
    check(fetches == f0, "R4 no fetch out of range", 64'(fetches), 64'(f0));
    xlate(32'hFF80_0042, 1'b0, pa, f, c);
    check(last_fetch == TB, "R5 first slot address", last_fetch, TB);
    check(pa == {28'h0ABCD, 13'h0042} && f == 0, "R6 translated paddr", pa, {28'h0ABCD, 13'h0042});
    check(c == 3, "R6 miss latency", 64'(c), 3);
    xlate(32'hFFFF_FABC, 1'b0, pa, f, c);
    check(last_fetch == TB + 41'h1FF8, "R5 last slot code0", last_fetch, TB + 41'h1FF8);
    check(pa == {28'h00777, 13'h1ABC}, "R6 last slot paddr", pa, {28'h00777, 13'h1ABC});
    wr_reg(2'd0, mk_ctrl(1, 0, 3'd7));
    xlate(32'hBFFF_FFFF, 1'b0, pa, f, c);
    check(f == 3'd1, "R4 below base code7", 64'(f), 1);
    xlate(32'hC000_2010, 1'b1, pa, f, c);
    check(last_fetch == TB + 41'h8, "R5 slot 1 code7", last_fetch, TB + 41'h8);
    check(pa == {28'h12345, 13'h0010} && f == 0, "R6 code7 paddr", pa, {28'h12345, 13'h0010});
    wr_reg(2'd0, mk_ctrl(1, 0, 3'd3));
    xlate(32'hFBFF_FFFF, 1'b0, pa, f, c);
    check(f == 3'd1, "R4 below base code3", 64'(f), 1);
    f0 = fetches;
    xlate(32'hFC00_0000, 1'b0, pa, f, c);
    check(fetches == f0 + 1 && last_fetch == TB, "R4 base code3 in window", last_fetch, TB);
  endtask

  task automatic t_faults();
    logic [40:0] pa; logic [2:0] f; int c;
    mem[TB + 41'h10] = 64'd0;
    mem[TB + 41'h18] = mk_ent(1, 1, 1, 28'h00111);
    mem[TB + 41'h20] = mk_ent(1, 0, 0, 28'h00222);
    mem[TB + 41'h28] = mk_ent(0, 1, 0, 28'h00333);
    mem[TB + 41'h30] = mk_ent(1, 1, 0, 28'h00444);
    wr_reg(2'd0, mk_ctrl(1, 0, 3'd0));
    xlate(32'hFF80_4000, 1'b0, pa, f, c);
    check(f == 3'd2 && pa == 0, "R7 invalid entry", 64'(f), 2);
    xlate(32'hFF80_6000, 1'b0, pa, f, c);
    check(f == 3'd4, "R8 size mismatch", 64'(f), 4);
    xlate(32'hFF80_8000, 1'b1, pa, f, c);
    check(f == 3'd3 && pa == 0, "R9 write protect", 64'(f), 3);
    wr_reg(2'd0, mk_ctrl(1, 0, 3'd0));
    xlate(32'hFF80_8004, 1'b0, pa, f, c);
    check(f == 0 && pa == {28'h00222, 13'h4}, "R9 read allowed", pa, {28'h00222, 13'h4});
    xlate(32'hFF80_A000, 1'b1, pa, f, c);
    check(f == 3'd2, "R7 invalid beats others", 64'(f), 2);
    xlate(32'hFF80_C000, 1'b1, pa, f, c);
    check(f == 3'd4, "R8 size beats protect", 64'(f), 4);
    wr_reg(2'd0, mk_ctrl(1, 1, 3'd0));
    xlate(32'hFF80_6008, 1'b0, pa, f, c);
    check(f == 0 && pa == {28'h00111, 13'h8}, "R2 64K page bit matches", pa, {28'h00111, 13'h8});
  endtask

  task automatic t_cache();
    logic [40:0] pa; logic [2:0] f; int c; int f0;
    mem[TB + 41'h40] = mk_ent(1, 0, 1, 28'h05555);
    mem[TB + 41'h48] = mk_ent(1, 0, 0, 28'h06666);
    wr_reg(2'd0, mk_ctrl(1, 0, 3'd0));
    xlate(32'hFF81_0000, 1'b0, pa, f, c);
    f0 = fetches;
    xlate(32'hFF81_0123, 1'b0, pa, f, c);
    check(fetches == f0 && c == 1, "R10 cache hit no fetch", 64'(c), 1);
    check(pa == {28'h05555, 13'h0123}, "R10 cache hit paddr", pa, {28'h05555, 13'h0123});
    wr_reg(2'd2, 64'h0000_0000_FF81_2000);
    xlate(32'hFF81_0004, 1'b0, pa, f, c);
    check(fetches == f0, "R11 other-page flush keeps entry", 64'(fetches), 64'(f0));
    wr_reg(2'd2, 64'h0000_0000_FF81_0000);
    xlate(32'hFF81_0008, 1'b0, pa, f, c);
    check(fetches == f0 + 1, "R11 matching flush drops entry", 64'(fetches), 64'(f0 + 1));
    wr_reg(2'd1, 64'(TB));
    xlate(32'hFF81_000C, 1'b0, pa, f, c);
    check(fetches == f0 + 2, "R11 table base write drops entry", 64'(fetches), 64'(f0 + 2));
    wr_reg(2'd0, mk_ctrl(1, 0, 3'd0));
    xlate(32'hFF81_0010, 1'b0, pa, f, c);
    check(fetches == f0 + 3, "R11 control write drops entry", 64'(fetches), 64'(f0 + 3));
    xlate(32'hFF81_2000, 1'b0, pa, f, c);
    f0 = fetches;
    xlate(32'hFF81_2000, 1'b1, pa, f, c);
    check(f == 3'd3 && fetches == f0 && c == 1, "R10 cached write permission", 64'(f), 3);
  endtask

  task automatic t_backpressure();
    logic [40:0] pa; logic [2:0] f; int c; logic [40:0] a0;
    wr_reg(2'd0, mk_ctrl(1, 0, 3'd0));
    rsp_ready = 1'b0;
    xlate(32'hFF80_0100, 1'b0, pa, f, c);
    repeat (3) @(negedge clk);
    check(rsp_valid && rsp_paddr == pa && rsp_fault == f, "R12 response held", rsp_paddr, pa);
    check(!req_ready, "R12 not ready while busy", 64'(req_ready), 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R12 released", 64'(rsp_valid), 0);
    mem_req_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'hFF81_4000; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    a0 = mem_req_addr;
    repeat (3) @(negedge clk);
    check(mem_req_valid && mem_req_addr == a0 && a0 == TB + 41'h50, "R12 mem request held", mem_req_addr, TB + 41'h50);
    mem_req_ready = 1'b1;
    c = 0;
    while (!rsp_valid && c < 20) begin @(negedge clk); c++; end
    check(rsp_valid && rsp_fault == 3'd2, "R12 stalled fetch completes", 64'(rsp_fault), 2);
    @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_window();
    t_faults();
    t_cache();
    t_backpressure();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule